// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit sits between a serial bus controller core and the chip interrupt fabric. It gathers eight event sources into one sticky status register and gates them with a mask register. It then drives one registered interrupt line. Six sources arrive as single-cycle pulses. The two FIFO data-request sources arrive as levels, and their status bits track the level while it holds.

Software reaches the unit through a small register port with one address bit. The mask is read and written directly. The status register reads back the latched events and is cleared by writing ones. The packet-complete source ignores the mask and always raises the interrupt while its status bit is set.

Top module: `isr_unit`

## Requirements
- R1: After reset the status register and the mask register read 0x00, and irq_o is low.
- R2: A pulse on pulse_i[k] sets status bit k+2. The map is: bit 2 arbitration lost, bit 3 no-acknowledge, bit 4 RX FIFO underflow, bit 5 TX FIFO overflow, bit 6 all packets complete, bit 7 packet transfer complete. The bit is readable the cycle after the pulse edge.
- R3: A set status bit stays set, with no further event, until software clears it.
- R4: A write with reg_addr_i=1 clears every status bit whose write-data bit is one. Bits written as zero are left unchanged.
- R5: When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R6: A write with reg_addr_i=0 loads all eight mask bits, and the mask reads back at reg_addr_i=0. Mask writes leave the status unchanged.
- R7: irq_o is registered. It goes high one cycle after any bit is set in both status and mask, and low one cycle after no such bit remains (bit 7 aside).
- R8: Status bit 7 drives irq_o one cycle later whatever the mask holds.
- R9: Status bit 1 follows tx_req_i and bit 0 follows rx_req_i. Each is set in every cycle its level is high, so a clear has no effect while the level holds. After the level drops, a clear removes the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 6 | Single-cycle event pulses for status bits 7..2 |
| tx_req_i | input | 1 | TX FIFO data-request level |
| rx_req_i | input | 1 | RX FIFO data-request level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 mask, 1 status |
| reg_wdata_i | input | 8 | Write data (mask value or ones-to-clear) |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a new event on the bit being cleared. A related case is a data-request level that stays high through a clear. Both need the event and the write strobe lined up to one edge. Directed sequences drive a pulse together with a matching ones-to-clear write, and hold tx_req_i high across a clear and then drop it. Seeded random cycles mix pulses, levels, mask writes and clears, so such overlaps also occur with other bits active. The one-cycle interrupt lag is checked by sampling irq_o at the edge that latches a status bit and again at the next edge.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int NUM_SRC   = 8;
  localparam int NUM_LVL   = 2;
  localparam int NUM_PULSE = NUM_SRC - NUM_LVL;
  localparam int NMI_IDX   = 7;
  localparam int TXREQ_IDX = 1;
  localparam int RXREQ_IDX = 0;
  localparam logic ADDR_MASK = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/isr_status_bank.sv
module isr_status_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    // set has priority so a coincident event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[i]) bit_q <= 1'b1;
      else if (clr_i[i]) bit_q <= 1'b0;
    end
    assign stat_o[i] = bit_q;
  end
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end
  assign mask_o = mask_q;
endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen #(
  parameter int W   = 8,
  parameter int NMI = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] en_v;
  logic         irq_d, irq_q;

  for (genvar i = 0; i < W; i++) begin : g_en
    if (i == NMI) begin : g_nmi
      assign en_v[i] = 1'b1;
    end else begin : g_msk
      assign en_v[i] = mask_i[i];
    end
  end

  assign irq_d = |(stat_i & en_v);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PULSE-1:0] pulse_i,
  input  logic                 tx_req_i,
  input  logic                 rx_req_i,
  input  logic                 reg_we_i,
  input  logic                 reg_addr_i,
  input  logic [NUM_SRC-1:0]   reg_wdata_i,
  output logic [NUM_SRC-1:0]   reg_rdata_o,
  output logic                 irq_o
);
  src_vec_t set_v, clr_v, status_q, mask_q;
  logic     mask_we;

  always_comb begin
    set_v            = '0;
    set_v[NUM_SRC-1:NUM_LVL] = pulse_i;
    set_v[TXREQ_IDX] = tx_req_i;
    set_v[RXREQ_IDX] = rx_req_i;
  end

  assign clr_v   = (reg_we_i && reg_addr_i == ADDR_STAT) ? reg_wdata_i : '0;
  assign mask_we = reg_we_i && reg_addr_i == ADDR_MASK;

  isr_status_bank #(.W(NUM_SRC)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .stat_o (status_q)
  );

  isr_mask_reg #(.W(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_q)
  );

  isr_irq_gen #(.W(NUM_SRC), .NMI(NMI_IDX)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (status_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  assign reg_rdata_o = (reg_addr_i == ADDR_STAT) ? status_q : mask_q;
endmodule

// File: rtl/isr_unit_chk.sv
module isr_unit_chk
  import isr_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_PULSE-1:0] pulse_i,
  input logic                 tx_req_i,
  input logic                 rx_req_i,
  input logic                 reg_we_i,
  input logic                 reg_addr_i,
  input logic [NUM_SRC-1:0]   reg_wdata_i,
  input logic [NUM_SRC-1:0]   stat_i,
  input logic [NUM_SRC-1:0]   mask_i,
  input logic                 irq_o
);
  logic [NUM_SRC-1:0] wr_clr;
  assign wr_clr = (reg_we_i && reg_addr_i) ? reg_wdata_i : '0;

  // R3: uncleared bits never drop
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_i) & ~$past(wr_clr)) & ~stat_i) == '0));

  // R2, R5: a pulse always lands, even against a clear
  p_pulse_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i != '0) |=> (({$past(pulse_i), 2'b00} & ~stat_i) == '0));

  p_mask_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i) |=> (mask_i == $past(reg_wdata_i)));

  p_irq_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_i & mask_i) != '0) |=> irq_o);

  p_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((stat_i & mask_i) == '0) && !stat_i[NMI_IDX]) |=> !irq_o);

  p_nmi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[NMI_IDX] |=> irq_o);

  p_txlvl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i |=> stat_i[TXREQ_IDX]);

  p_rxlvl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_req_i |=> stat_i[RXREQ_IDX]);
endmodule

bind isr_unit isr_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pulse_i     (pulse_i),
  .tx_req_i    (tx_req_i),
  .rx_req_i    (rx_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .stat_i      (status_q),
  .mask_i      (mask_q),
  .irq_o       (irq_o)
);

// File: tb/tb_isr_unit.sv
module tb_isr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] pulse;
  logic       tx_req, rx_req, we, addr;
  logic [7:0] wdata, rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_stat, m_mask;
  logic       m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .tx_req_i(tx_req),
    .rx_req_i(rx_req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] f_stat(logic [7:0] cur, logic [7:0] set, logic [7:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic f_irq(logic [7:0] st, logic [7:0] mk);
    return (|(st & mk)) | st[7];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [5:0] p, logic tx, logic rx, logic w, logic a, logic [7:0] d);
    logic [7:0] set, clr, n_stat, n_mask;
    logic n_irq;
    pulse = p; tx_req = tx; rx_req = rx; we = w; addr = a; wdata = d;
    set    = {p, tx, rx};
    clr    = (w && a) ? d : 8'h00;
    n_irq  = f_irq(m_stat, m_mask);
    n_stat = f_stat(m_stat, set, clr);
    n_mask = (w && !a) ? d : m_mask;
    @(posedge clk); #1;
    m_stat = n_stat; m_mask = n_mask; m_irq = n_irq;
    pulse = '0; we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic verify(string tag);
    logic [7:0] v;
    rd(1'b1, v); chk({tag, " status R4"}, v, m_stat);
    rd(1'b0, v); chk({tag, " mask R6"}, v, m_mask);
    chk({tag, " irq R7"}, {7'd0, irq}, {7'd0, m_irq});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1357));
    rst_n = 1'b0; pulse = '0; tx_req = 0; rx_req = 0; we = 0; addr = 0; wdata = '0;
    m_stat = '0; m_mask = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(1'b1, v); chk("R1 status", v, 8'h00);
    rd(1'b0, v); chk("R1 mask", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 each pulse source maps to bit k+2
    for (int k = 0; k < 6; k++) begin
      cyc(6'(1 << k), 0, 0, 0, 0, 8'h00);
      rd(1'b1, v); chk("R2 bit map", v, 8'(1 << (k + 2)));
      cyc(6'h00, 0, 0, 1, 1, 8'hff);
      verify("R2 clear");
    end

    // R3 stickiness
    cyc(6'h02, 0, 0, 0, 0, 8'h00);
    repeat (3) cyc(6'h00, 0, 0, 0, 0, 8'h00);
    rd(1'b1, v); chk("R3 sticky", v, 8'h08);

    // R4 zeros in clear word leave bits, ones clear
    cyc(6'h00, 0, 0, 1, 1, 8'hf7);
    rd(1'b1, v); chk("R4 zero-write keeps", v, 8'h08);
    cyc(6'h00, 0, 0, 1, 1, 8'h08);
    rd(1'b1, v); chk("R4 one-write clears", v, 8'h00);

    // R5 event wins over same-cycle clear
    cyc(6'h02, 0, 0, 0, 0, 8'h00);
    cyc(6'h02, 0, 0, 1, 1, 8'h08);
    rd(1'b1, v); chk("R5 event beats clear", v, 8'h08);
    cyc(6'h00, 0, 0, 1, 1, 8'hff);

    // R6 mask load and readback, status untouched
    cyc(6'h04, 0, 0, 0, 0, 8'h00);
    cyc(6'h00, 0, 0, 1, 0, 8'h21);
    rd(1'b0, v); chk("R6 mask readback", v, 8'h21);
    rd(1'b1, v); chk("R6 status untouched", v, 8'h10);
    cyc(6'h00, 0, 0, 1, 1, 8'hff);
    cyc(6'h00, 0, 0, 0, 0, 8'h00);

    // R7 registered irq: one cycle lag
    cyc(6'h00, 0, 0, 1, 0, 8'h04);
    cyc(6'h01, 0, 0, 0, 0, 8'h00);
    chk("R7 irq lags status", {7'd0, irq}, 8'h00);
    cyc(6'h00, 0, 0, 0, 0, 8'h00);
    chk("R7 irq asserted", {7'd0, irq}, 8'h01);
    cyc(6'h00, 0, 0, 1, 1, 8'h04);
    chk("R7 irq held one cycle", {7'd0, irq}, 8'h01);
    cyc(6'h00, 0, 0, 0, 0, 8'h00);
    chk("R7 irq dropped", {7'd0, irq}, 8'h00);

    // R8 packet-complete ignores mask
    cyc(6'h00, 0, 0, 1, 0, 8'h00);
    cyc(6'h20, 0, 0, 0, 0, 8'h00);
    cyc(6'h00, 0, 0, 0, 0, 8'h00);
    chk("R8 unmasked completion irq", {7'd0, irq}, 8'h01);
    cyc(6'h00, 0, 0, 1, 1, 8'h80);
    cyc(6'h00, 0, 0, 0, 0, 8'h00);
    chk("R8 irq low after clear", {7'd0, irq}, 8'h00);

    // R9 level-driven request bits
    cyc(6'h00, 1, 0, 0, 0, 8'h00);
    rd(1'b1, v); chk("R9 tx level sets", v, 8'h02);
    cyc(6'h00, 1, 1, 1, 1, 8'h03);
    rd(1'b1, v); chk("R9 clear ignored while high", v, 8'h03);
    cyc(6'h00, 0, 0, 1, 1, 8'h03);
    rd(1'b1, v); chk("R9 cleared after drop", v, 8'h00);

    // random mix against model
    for (int i = 0; i < 600; i++) begin
      logic [5:0] p;
      p = ($urandom % 4 == 0) ? 6'($urandom) : 6'h00;
      cyc(p, ($urandom % 5) == 0, ($urandom % 5) == 0,
          ($urandom % 3) == 0, 1'($urandom), 8'($urandom));
      verify("rand");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule